// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block is a small pool of reservation-station entries in front of one class of functional unit in an out-of-order core. A dispatch request carries an operation, two source operands and the reorder-buffer number of the instruction's own result. Each source arrives either as a ready value or as the reorder-buffer number of the instruction that will produce it. A request is taken only when a station is free and the reorder buffer reports a free slot. Because operands are named by reorder-buffer numbers, write-after-write and write-after-read conflicts between instructions never reach the stations.

Entries waiting on a source watch the single result bus. When a broadcast tag matches, the entry takes the value. An entry whose two sources both hold values may be sent to the functional unit. When several are eligible, the one allocated earliest goes first, and only one leaves per cycle. A sent entry stays occupied until its own result tag appears on the result bus, and is then released. A flush empties the whole pool in one cycle.

Top module: `rs_array`

## Requirements
- R1: After synchronous active-low reset, no entry is occupied: `iss_valid` is 0 and `disp_ready` equals `rob_has_slot`.
- R2: `disp_ready` is 1 only when `rob_has_slot` is 1, at least one station is free and `flush` is 0. A request made while `disp_ready` is 0 is not stored.
- R3: An accepted entry presents its operation, both source values and its destination tag on `iss_op`, `iss_a`, `iss_b` and `iss_dst_tag` when it issues.
- R4: A source whose ready flag is 0 takes `res_data` at the clock edge where `res_valid` is 1 and `res_tag` equals its tag. A broadcast with a different tag, or a matching tag with `res_valid` at 0, leaves it waiting.
- R5: An entry is offered on `iss_valid` only when both of its sources hold values. The earliest cycle is the one after the last value was taken.
- R6: Among eligible entries the earliest-allocated one is offered. At most one is offered per cycle, and an entry that has issued is not offered again.
- R7: An issued entry stays occupied until `res_valid` is 1 with `res_tag` equal to its destination tag. It is free from the next cycle.
- R8: If the result bus broadcasts a source's tag in the same cycle that the entry is dispatched, the broadcast value is stored in the new entry.
- R9: `flush` empties every entry at the next edge, accepts no dispatch in its cycle and holds `iss_valid` at 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Empty all entries |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 4 | Operation code |
| disp_a_ready | input | 1 | 1: source A value given; 0: waiting on tag |
| disp_a_value | input | 16 | Source A value |
| disp_a_tag | input | 3 | Source A producer reorder-buffer number |
| disp_b_ready | input | 1 | 1: source B value given; 0: waiting on tag |
| disp_b_value | input | 16 | Source B value |
| disp_b_tag | input | 3 | Source B producer reorder-buffer number |
| disp_dst_tag | input | 3 | Reorder-buffer number of this instruction |
| rob_has_slot | input | 1 | Reorder buffer can take one more instruction |
| disp_ready | output | 1 | Request will be accepted this cycle |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 3 | Result bus tag |
| res_data | input | 16 | Result bus value |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_op | output | 4 | Issued operation |
| iss_a | output | 16 | Issued source A |
| iss_b | output | 16 | Issued source B |
| iss_dst_tag | output | 3 | Issued destination tag |

## Verification
Dispatch and result capture can fall in the same cycle. The bench provokes this by presenting a request whose sources wait on a tag while the result bus broadcasts that tag. It judges the outcome by the entry issuing in the next cycle with the broadcast value. A second coincidence is a result that releases one entry and wakes another in the same cycle. The bench drives this in its vector table and judges it by the woken entry issuing next while the released station can be reused.

// File: rtl/rs_pkg.sv
// Shared widths and types for the reservation station array.
// Assumes reorder-buffer numbers are the only producer names in use.
package rs_pkg;
    parameter int DATA_W = 16;
    parameter int TAG_W  = 3;
    parameter int OP_W   = 4;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        opnd_t            a;
        opnd_t            b;
        logic [TAG_W-1:0] dst;
    } uop_t;

    // Return the operand with the bus value taken if it was waiting on that tag.
    function automatic opnd_t snoop(opnd_t o, logic cv, logic [TAG_W-1:0] ct,
                                    logic [DATA_W-1:0] cd);
        opnd_t r;
        r = o;
        if (!o.rdy && cv && (o.tag == ct)) begin
            r.rdy = 1'b1;
            r.val = cd;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_alloc.sv
// Free-station finder: picks the lowest-numbered empty entry for a dispatch.
// Assumes req is already qualified by reorder-buffer space and flush.
module rs_alloc #(
    parameter int NUM_ENT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [NUM_ENT-1:0] valid,
    output logic [NUM_ENT-1:0] grant,
    output logic               any_free
);
    logic [NUM_ENT:0] seen;

    // Priority scan from entry 0 upward for the first empty slot.
    always_comb begin
        seen[0] = 1'b0;
        for (int i = 0; i < NUM_ENT; i++) begin
            grant[i]    = req && !valid[i] && !seen[i];
            seen[i+1]   = seen[i] || !valid[i];
        end
        any_free = seen[NUM_ENT];
    end

    // R2: a grant targets exactly one empty station.
    p_alloc_empty_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & valid) == '0));
    p_alloc_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && any_free) |-> (grant != '0));
endmodule

// File: rtl/rs_age_sel.sv
// Oldest-first issue selector built on an age matrix.
// older[i][j] set means entry i was allocated before entry j.
// Assumes at most one allocation per cycle.
module rs_age_sel #(
    parameter int NUM_ENT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ENT-1:0] alloc,
    input  logic [NUM_ENT-1:0] ready,
    output logic [NUM_ENT-1:0] grant
);
    logic [NUM_ENT-1:0] older [NUM_ENT];
    logic [NUM_ENT-1:0] blocked;

    // Update age relations when a new entry is allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) older[i] <= '0;
        end else begin
            for (int k = 0; k < NUM_ENT; k++) begin
                if (alloc[k]) begin
                    for (int j = 0; j < NUM_ENT; j++) begin
                        if (j != k) begin
                            older[k][j] <= 1'b0;
                            older[j][k] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // Grant the ready entry that no other ready entry predates.
    always_comb begin
        for (int i = 0; i < NUM_ENT; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < NUM_ENT; j++) begin
                if (j != i && ready[j] && older[j][i]) blocked[i] = 1'b1;
            end
            grant[i] = ready[i] && !blocked[i];
        end
    end

    // R6: one grant at most, and some grant whenever an entry is eligible.
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_no_starve_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready != '0) |-> (grant != '0));
endmodule

// File: rtl/rs_entry.sv
// One reservation station: holds an operation, snoops the result bus for
// missing sources, and releases itself when its own result is broadcast.
// Assumes alloc and grant are never both set for the same entry.
module rs_entry
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  uop_t              disp_uop,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    input  logic              grant,
    output logic              valid_o,
    output logic              ready_o,
    output logic              free_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o,
    output logic [TAG_W-1:0]  dst_o
);
    logic valid;
    logic issued;
    uop_t u;

    // Release when an issued entry sees its own tag on the bus.
    assign free_o  = valid && issued && cdb_valid && (cdb_tag == u.dst);
    assign ready_o = valid && !issued && u.a.rdy && u.b.rdy;
    assign valid_o = valid;
    assign op_o    = u.op;
    assign a_o     = u.a.val;
    assign b_o     = u.b.val;
    assign dst_o   = u.dst;

    // Entry state: allocate, capture sources, mark issue, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            issued <= 1'b0;
            u      <= '0;
        end else if (flush) begin
            valid  <= 1'b0;
            issued <= 1'b0;
        end else if (alloc) begin
            valid  <= 1'b1;
            issued <= 1'b0;
            u.op   <= disp_uop.op;
            u.dst  <= disp_uop.dst;
            u.a    <= snoop(disp_uop.a, cdb_valid, cdb_tag, cdb_data);
            u.b    <= snoop(disp_uop.b, cdb_valid, cdb_tag, cdb_data);
        end else if (valid) begin
            if (free_o) valid  <= 1'b0;
            if (grant)  issued <= 1'b1;
            u.a <= snoop(u.a, cdb_valid, cdb_tag, cdb_data);
            u.b <= snoop(u.b, cdb_valid, cdb_tag, cdb_data);
        end
    end

    // R5: the selector only picks an unissued entry with both sources present.
    p_grant_has_operands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (valid && !issued && u.a.rdy && u.b.rdy));
    // R6: an issued entry is never picked again.
    p_no_reissue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && issued) |-> !grant);
    // R4: a waiting source takes the matching broadcast value.
    p_capture_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flush && !u.a.rdy && cdb_valid && cdb_tag == u.a.tag)
        |=> (u.a.rdy && u.a.val == $past(cdb_data)));
    // R7: occupancy persists until the entry's own broadcast.
    p_hold_until_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flush && !(cdb_valid && cdb_tag == u.dst)) |=> valid);
    // R8: a broadcast during dispatch lands in the new entry.
    p_dispatch_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush && !disp_uop.a.rdy && cdb_valid && cdb_tag == disp_uop.a.tag)
        |=> (u.a.rdy && u.a.val == $past(cdb_data)));
endmodule

// File: rtl/rs_array.sv
// Reservation station array for one functional-unit class.
// Accepts one dispatch per cycle when a station and a reorder-buffer slot
// are free, wakes entries from the result bus, and issues the oldest ready
// entry each cycle. Assumes the functional unit accepts every issue.
module rs_array
    import rs_pkg::*;
#(
    parameter int NUM_ENT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              disp_valid,
    input  logic [OP_W-1:0]   disp_op,
    input  logic              disp_a_ready,
    input  logic [DATA_W-1:0] disp_a_value,
    input  logic [TAG_W-1:0]  disp_a_tag,
    input  logic              disp_b_ready,
    input  logic [DATA_W-1:0] disp_b_value,
    input  logic [TAG_W-1:0]  disp_b_tag,
    input  logic [TAG_W-1:0]  disp_dst_tag,
    input  logic              rob_has_slot,
    output logic              disp_ready,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              iss_valid,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    output logic [TAG_W-1:0]  iss_dst_tag
);
    logic [NUM_ENT-1:0] valid_vec, ready_vec, free_vec, alloc_vec, grant_vec;
    logic [OP_W-1:0]    e_op  [NUM_ENT];
    logic [DATA_W-1:0]  e_a   [NUM_ENT];
    logic [DATA_W-1:0]  e_b   [NUM_ENT];
    logic [TAG_W-1:0]   e_dst [NUM_ENT];
    logic               any_free;
    logic               alloc_req;
    uop_t               disp_uop;

    // Dispatch handshake and request packing.
    assign disp_ready = rob_has_slot && any_free && !flush;
    assign alloc_req  = disp_valid && disp_ready;
    assign disp_uop   = '{op:  disp_op,
                          a:   '{rdy: disp_a_ready, tag: disp_a_tag, val: disp_a_value},
                          b:   '{rdy: disp_b_ready, tag: disp_b_tag, val: disp_b_value},
                          dst: disp_dst_tag};

    rs_alloc #(.NUM_ENT(NUM_ENT)) u_alloc (
        .clk(clk), .rst_n(rst_n), .req(alloc_req), .valid(valid_vec),
        .grant(alloc_vec), .any_free(any_free)
    );

    rs_age_sel #(.NUM_ENT(NUM_ENT)) u_sel (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_vec),
        .ready(ready_vec & {NUM_ENT{!flush}}), .grant(grant_vec)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        rs_entry u_ent (
            .clk(clk), .rst_n(rst_n), .flush(flush), .alloc(alloc_vec[g]),
            .disp_uop(disp_uop), .cdb_valid(res_valid), .cdb_tag(res_tag),
            .cdb_data(res_data), .grant(grant_vec[g]),
            .valid_o(valid_vec[g]), .ready_o(ready_vec[g]), .free_o(free_vec[g]),
            .op_o(e_op[g]), .a_o(e_a[g]), .b_o(e_b[g]), .dst_o(e_dst[g])
        );
    end

    // AND-OR mux of the granted entry onto the issue port.
    always_comb begin
        iss_valid   = |grant_vec;
        iss_op      = '0;
        iss_a       = '0;
        iss_b       = '0;
        iss_dst_tag = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            iss_op      |= e_op[i]  & {OP_W{grant_vec[i]}};
            iss_a       |= e_a[i]   & {DATA_W{grant_vec[i]}};
            iss_b       |= e_b[i]   & {DATA_W{grant_vec[i]}};
            iss_dst_tag |= e_dst[i] & {TAG_W{grant_vec[i]}};
        end
    end

    // R9: a flush leaves no entry occupied.
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));
    // R7: occupancy changes only by one allocation and the broadcast releases.
    p_occupancy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(flush)) |->
        ($countones(valid_vec) == $past($countones(valid_vec)) + int'($past(alloc_req))
                                  - $past($countones(free_vec))));
endmodule

// File: tb/sim_rs_array.sv
`timescale 1ns/1ps
module sim_rs_array;
    logic        clk = 1'b0;
    logic        rst_n, flush, disp_valid, disp_a_ready, disp_b_ready;
    logic [3:0]  disp_op;
    logic [15:0] disp_a_value, disp_b_value, res_data;
    logic [2:0]  disp_a_tag, disp_b_tag, disp_dst_tag, res_tag;
    logic        rob_has_slot, res_valid, disp_ready, iss_valid;
    logic [3:0]  iss_op;
    logic [15:0] iss_a, iss_b;
    logic [2:0]  iss_dst_tag;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rs_array u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
        .disp_op(disp_op), .disp_a_ready(disp_a_ready), .disp_a_value(disp_a_value),
        .disp_a_tag(disp_a_tag), .disp_b_ready(disp_b_ready), .disp_b_value(disp_b_value),
        .disp_b_tag(disp_b_tag), .disp_dst_tag(disp_dst_tag), .rob_has_slot(rob_has_slot),
        .disp_ready(disp_ready), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data), .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a),
        .iss_b(iss_b), .iss_dst_tag(iss_dst_tag)
    );

    typedef struct packed {
        logic dv; logic [3:0] op;
        logic ar; logic [15:0] av; logic [2:0] at;
        logic br; logic [15:0] bv; logic [2:0] bt;
        logic [2:0] dst; logic rob;
        logic cv; logic [2:0] ct; logic [15:0] cd; logic fl;
        logic e_rdy; logic e_iv; logic [15:0] e_a; logic [15:0] e_b; logic [2:0] e_dst;
    } vec_t;

    // One row per cycle; expectations are for the cycle the row is applied.
    localparam vec_t TBL [10] = '{
        '{1,1, 1,10,0, 1,20,0, 1,1, 0,0,0,  0, 1,0, 0, 0,0},
        '{1,2, 0,0,1,  1,5,0,  2,1, 0,0,0,  0, 1,1,10,20,1},
        '{1,3, 1,7,0,  0,0,2,  3,1, 0,0,0,  0, 1,0, 0, 0,0},
        '{0,0, 0,0,0,  0,0,0,  0,1, 1,1,30, 0, 1,0, 0, 0,0},
        '{0,0, 0,0,0,  0,0,0,  0,1, 0,0,0,  0, 1,1,30, 5,2},
        '{0,0, 0,0,0,  0,0,0,  0,1, 1,2,40, 0, 1,0, 0, 0,0},
        '{0,0, 0,0,0,  0,0,0,  0,1, 0,0,0,  0, 1,1, 7,40,3},
        '{0,0, 0,0,0,  0,0,0,  0,1, 1,3,0,  0, 1,0, 0, 0,0},
        '{1,5, 1,11,0, 1,12,0, 4,0, 0,0,0,  0, 0,0, 0, 0,0},
        '{0,0, 0,0,0,  0,0,0,  0,1, 0,0,0,  0, 1,0, 0, 0,0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic dv, input logic [3:0] op,
                         input logic ar, input logic [15:0] av, input logic [2:0] at,
                         input logic br, input logic [15:0] bv, input logic [2:0] bt,
                         input logic [2:0] dst, input logic rob, input logic cv,
                         input logic [2:0] ct, input logic [15:0] cd, input logic fl);
        disp_valid = dv; disp_op = op;
        disp_a_ready = ar; disp_a_value = av; disp_a_tag = at;
        disp_b_ready = br; disp_b_value = bv; disp_b_tag = bt;
        disp_dst_tag = dst; rob_has_slot = rob;
        res_valid = cv; res_tag = ct; res_data = cd; flush = fl;
        #1;
    endtask

    task automatic idle();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 0,0,0, 0);
    endtask

    task automatic nx();
        @(negedge clk);
    endtask

    task automatic expect_issue(input string req, input logic [15:0] a,
                                input logic [15:0] b, input logic [2:0] d);
        check(req, 32'(iss_valid), 1);
        check(req, 32'(iss_a), 32'(a));
        check(req, 32'(iss_b), 32'(b));
        check(req, 32'(iss_dst_tag), 32'(d));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        idle();
        repeat (3) nx();
        rst_n = 1'b1;
        idle();
        check("R1 reset ready", 32'(disp_ready), 1);
        check("R1 reset issue", 32'(iss_valid), 0);
        nx();

        // Vector table: dispatch, wake-up, release and stall (R2 R3 R4 R5 R7).
        for (int k = 0; k < 10; k++) begin
            drive(TBL[k].dv, TBL[k].op, TBL[k].ar, TBL[k].av, TBL[k].at,
                  TBL[k].br, TBL[k].bv, TBL[k].bt, TBL[k].dst, TBL[k].rob,
                  TBL[k].cv, TBL[k].ct, TBL[k].cd, TBL[k].fl);
            check($sformatf("R2 table row %0d ready", k), 32'(disp_ready), 32'(TBL[k].e_rdy));
            check($sformatf("R5 table row %0d issue", k), 32'(iss_valid), 32'(TBL[k].e_iv));
            if (TBL[k].e_iv) begin
                check($sformatf("R4 table row %0d a", k), 32'(iss_a), 32'(TBL[k].e_a));
                check($sformatf("R3 table row %0d b", k), 32'(iss_b), 32'(TBL[k].e_b));
                check($sformatf("R7 table row %0d dst", k), 32'(iss_dst_tag), 32'(TBL[k].e_dst));
            end
            nx();
        end

        // R6: younger entry in a lower slot must wait for the older one.
        drive(1,9, 1,1,0, 1,2,0, 4,1, 0,0,0, 0);  check("R6 d0", 32'(iss_valid), 0); nx();
        drive(1,1, 0,0,7, 1,3,0, 5,1, 0,0,0, 0);
        expect_issue("R3 first issue", 1, 2, 4);
        check("R3 op", 32'(iss_op), 9); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 1,4,0, 0);  check("R7 release", 32'(iss_valid), 0); nx();
        drive(1,2, 0,0,7, 1,8,0, 6,1, 0,0,0, 0);  check("R6 d3", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 1,7,99, 0); check("R5 same-cycle wake", 32'(iss_valid), 0); nx();
        idle(); expect_issue("R6 oldest first", 99, 3, 5); nx();
        idle(); expect_issue("R6 next oldest", 99, 8, 6); nx();
        idle(); check("R6 no reissue", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 0,0,0, 1); nx();

        // R4: non-matching or invalid broadcasts leave the source waiting.
        drive(1,3, 0,0,3, 1,2,0, 1,1, 0,0,0, 0);    check("R4 e0", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 1,2,77, 0);   check("R4 e1", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 0,3,66, 0);   check("R4 e2", 32'(iss_valid), 0); nx();
        idle(); check("R4 ignored broadcasts", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 1,3,16'h1234, 0); nx();
        idle(); expect_issue("R4 matched capture", 16'h1234, 2, 1); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 0,0,0, 1); nx();

        // R8: broadcast in the dispatch cycle reaches both sources.
        drive(1,4, 0,0,4, 0,0,4, 2,1, 1,4,16'h55, 0); check("R8 d", 32'(iss_valid), 0); nx();
        idle(); expect_issue("R8 bypass", 16'h55, 16'h55, 2); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 0,0,0, 1); nx();

        // R2: fill every station, then a rejected request is not stored.
        for (int k = 1; k <= 4; k++) begin
            drive(1,1, 0,0,7, 0,0,7, 3'(k),1, 0,0,0, 0);
            check("R2 fill ready", 32'(disp_ready), 1);
            nx();
        end
        drive(1,6, 1,1,0, 1,1,0, 6,1, 0,0,0, 0);
        check("R2 full stall", 32'(disp_ready), 0); nx();
        idle(); check("R2 rejected not stored", 32'(iss_valid), 0); nx();

        // R9: flush empties the pool and drops the dispatch in its cycle.
        drive(1,6, 1,1,0, 1,1,0, 6,1, 0,0,0, 1);
        check("R9 flush ready", 32'(disp_ready), 0);
        check("R9 flush issue", 32'(iss_valid), 0); nx();
        idle(); check("R9 empty after flush", 32'(disp_ready), 1);
        check("R9 flush dispatch dropped", 32'(iss_valid), 0); nx();
        drive(0,0, 0,0,0, 0,0,0, 0,1, 1,7,5, 0); nx();
        idle(); check("R9 old entries gone", 32'(iss_valid), 0); nx();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule